// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block sits between a processor core and its memory bus controller and absorbs stores so the core does not wait on the bus. Each store arrives as a line index, a 16-bit byte-enable mask and a full line of data. The block parks it in one of eight line-sized entries. The bus side drains those entries one at a time, oldest first, over a valid/ready handshake. Stores may come from the core or from a cache eviction path; the block treats both the same way.

Two things must both be set before a store may fold into an entry that already holds its line: a global coalesce enable and a per-store region permit. A merged store leaves with the older entry it joined, which can put it on the bus ahead of stores accepted before it. With either control clear, every store takes its own entry and the bus sees stores in acceptance order. A stall output tells the core that the offered store cannot be taken. An empty flag lets the core build a barrier that waits until every buffered store has left.

Top module: `wbuf_coalesce`

## Requirements
- R1: After reset, `empty_o` is 1, `dr_valid_o` is 0 and `st_stall_o` is 0.
- R2: A store taken while `coal_en_i` or `st_coal_ok_i` is 0 gets its own entry. Entries leave on the drain port in the order their stores were taken, one drain per entry.
- R3: A drained entry shows its line index on `dr_line_o`. Byte lane k (bits 8k+7..8k) of `dr_data_o` belongs to `dr_be_o` bit k. Lanes whose enable was never set read as zero.
- R4: A store taken with `coal_en_i` and `st_coal_ok_i` both 1, whose line matches a mergeable entry, creates no new entry. The entry's enables become the OR of old and new, and the lanes enabled by the store take the new bytes.
- R5: The entry being offered on the drain port (`dr_valid_o` is 1) is never a merge target. A store to its line takes a new entry, or stalls if the buffer is full.
- R6: `st_stall_o` is 1 only when all eight entries are occupied and the offered store cannot merge. A stalled store is not taken. Once one entry has drained, a non-merging store is taken again.
- R7: When all entries are occupied, a store that can merge sees `st_stall_o` at 0 and is taken.
- R8: An entry leaves only on a cycle where `dr_valid_o` and `dr_ready_i` are both 1. While `dr_ready_i` is 0, the drain outputs hold steady.
- R9: `empty_o` is 1 exactly when no entry is occupied.
- R10: A store merged into an older entry is drained with that entry, ahead of stores taken between the two.
- R11: When two entries hold the same line, a merging store joins the younger one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coal_en_i | input | 1 | Global permission to merge stores |
| st_valid_i | input | 1 | Store offered this cycle |
| st_line_i | input | LINE_AW | Line index of the store |
| st_be_i | input | LINE_BYTES | Byte enables of the store |
| st_data_i | input | LINE_BYTES*8 | Store data, byte lane k at bits 8k+7..8k |
| st_coal_ok_i | input | 1 | Region permit for merging this store |
| st_stall_o | output | 1 | Offered store cannot be taken |
| dr_valid_o | output | 1 | Oldest entry offered to the bus |
| dr_ready_i | input | 1 | Bus takes the offered entry |
| dr_line_o | output | LINE_AW | Line index of the offered entry |
| dr_be_o | output | LINE_BYTES | Byte enables of the offered entry |
| dr_data_o | output | LINE_BYTES*8 | Data of the offered entry |
| empty_o | output | 1 | No entry occupied |

## Verification
A wrong age order or a lost allocation shows up as the wrong line or data on the drain port, at the next drain after the fault. A merge that lands in the wrong entry shows up as merged bytes leaving with the wrong line, or too early or too late. A slip in the occupancy count is visible within one cycle: either `st_stall_o` rises while a slot is still free, or a store is taken into a full buffer and a later drain is missing. A merge into the head entry changes the drain outputs while the bus has not yet taken them.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;

   // index width for an array of n slots, at least one bit
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // what the buffer does with the store offered this cycle
   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_MERGE = 2'd1,
      ACT_ALLOC = 2'd2,
      ACT_BLOCK = 2'd3
   } st_action_e;

endpackage

// File: rtl/wbuf_free_pick.sv
`timescale 1ns/1ps
module wbuf_free_pick #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N-1:0]     busy_i,
   output logic             any_free_o,
   output logic [IDX_W-1:0] free_idx_o
);

   // lowest numbered free slot wins
   always_comb begin
      free_idx_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (!busy_i[k]) free_idx_o = IDX_W'(k);
      end
   end

   assign any_free_o = ~&busy_i;

endmodule

// File: rtl/wbuf_age_fifo.sv
`timescale 1ns/1ps
module wbuf_age_fifo #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [IDX_W-1:0] push_idx_i,
   input  logic             pop_i,
   output logic [IDX_W-1:0] head_idx_o,
   output logic             empty_o,
   output logic             full_o
);

   localparam int unsigned CNT_W = IDX_W + 1;

   logic [N-1:0][IDX_W-1:0] slot_q;
   logic [IDX_W-1:0]        rd_ptr_q;
   logic [IDX_W-1:0]        wr_ptr_q;
   logic [CNT_W-1:0]        count_q;

   assign head_idx_o = slot_q[rd_ptr_q];
   assign empty_o    = (count_q == '0);
   assign full_o     = (count_q == CNT_W'(N));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({push_i, pop_i})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (push_i) slot_q[wr_ptr_q] <= push_idx_i;
   end

   // a new entry may only be recorded while a slot is free (R6)
   assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i |-> !full_o);

   // the bus can only take an entry that exists (R8)
   assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i |-> !empty_o);

endmodule

// File: rtl/wbuf_line_match.sv
`timescale 1ns/1ps
module wbuf_line_match #(
   parameter int unsigned N       = 8,
   parameter int unsigned LINE_AW = 28,
   parameter int unsigned IDX_W   = 3
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [N-1:0]              valid_i,
   input  logic [N-1:0]              latest_i,
   input  logic [N-1:0][LINE_AW-1:0] line_i,
   input  logic [LINE_AW-1:0]        req_line_i,
   input  logic                      head_valid_i,
   input  logic [IDX_W-1:0]          head_idx_i,
   output logic                      hit_o,
   output logic [IDX_W-1:0]          hit_idx_o
);

   logic [N-1:0] same_latest;
   logic [N-1:0] cand;

   for (genvar e = 0; e < N; e++) begin : g_cmp
      assign same_latest[e] = valid_i[e] && latest_i[e] && (line_i[e] == req_line_i);
      assign cand[e]        = same_latest[e] && !(head_valid_i && (head_idx_i == IDX_W'(e)));
   end

   assign hit_o = |cand;

   always_comb begin
      hit_idx_o = '0;
      for (int k = 0; k < N; k++) begin
         if (cand[k]) hit_idx_o = IDX_W'(k);
      end
   end

   // at most one entry is the youngest holder of any line (R11)
   assert_single_latest_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(same_latest));

endmodule

// File: rtl/wbuf_coalesce.sv
`timescale 1ns/1ps
module wbuf_coalesce
   import wbuf_pkg::*;
#(
   parameter int unsigned ENTRIES       = 8,
   parameter int unsigned LINE_BYTES    = 16,
   parameter int unsigned LINE_AW       = 28,
   parameter bit          MERGE_SUPPORT = 1'b1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      coal_en_i,
   input  logic                      st_valid_i,
   input  logic [LINE_AW-1:0]        st_line_i,
   input  logic [LINE_BYTES-1:0]     st_be_i,
   input  logic [LINE_BYTES*8-1:0]   st_data_i,
   input  logic                      st_coal_ok_i,
   output logic                      st_stall_o,
   output logic                      dr_valid_o,
   input  logic                      dr_ready_i,
   output logic [LINE_AW-1:0]        dr_line_o,
   output logic [LINE_BYTES-1:0]     dr_be_o,
   output logic [LINE_BYTES*8-1:0]   dr_data_o,
   output logic                      empty_o
);

   localparam int unsigned IDX_W  = idx_width(ENTRIES);
   localparam int unsigned DATA_W = LINE_BYTES * 8;

   // elaboration checks on the parameter set
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two and at least 2");
   end
   if (LINE_BYTES < 1 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (LINE_AW < 1) begin : g_bad_aw
      $error("LINE_AW must be positive");
   end

   logic [ENTRIES-1:0]              valid_q;
   logic [ENTRIES-1:0]              latest_q;
   logic [ENTRIES-1:0][LINE_AW-1:0] line_q;
   logic [ENTRIES-1:0][LINE_BYTES-1:0] be_q;
   logic [ENTRIES-1:0][DATA_W-1:0]  data_q;

   logic             fifo_empty;
   logic             fifo_full;
   logic [IDX_W-1:0] head_idx;
   logic             any_free;
   logic [IDX_W-1:0] free_idx;
   logic             merge_hit;
   logic [IDX_W-1:0] merge_idx;
   logic             may_merge;
   st_action_e       action;
   logic             alloc_w;
   logic             merge_w;
   logic             drain_w;

   wbuf_free_pick #(.N(ENTRIES), .IDX_W(IDX_W)) free_i (
      .busy_i     (valid_q),
      .any_free_o (any_free),
      .free_idx_o (free_idx)
   );

   wbuf_age_fifo #(.N(ENTRIES), .IDX_W(IDX_W)) age_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (alloc_w),
      .push_idx_i (free_idx),
      .pop_i      (drain_w),
      .head_idx_o (head_idx),
      .empty_o    (fifo_empty),
      .full_o     (fifo_full)
   );

   if (MERGE_SUPPORT) begin : g_merge
      wbuf_line_match #(.N(ENTRIES), .LINE_AW(LINE_AW), .IDX_W(IDX_W)) match_i (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .valid_i      (valid_q),
         .latest_i     (latest_q),
         .line_i       (line_q),
         .req_line_i   (st_line_i),
         .head_valid_i (!fifo_empty),
         .head_idx_i   (head_idx),
         .hit_o        (merge_hit),
         .hit_idx_o    (merge_idx)
      );
      assign may_merge = coal_en_i && st_coal_ok_i && merge_hit;
   end else begin : g_no_merge
      assign merge_hit = 1'b0;
      assign merge_idx = '0;
      assign may_merge = 1'b0;
   end

   // decision for the offered store
   always_comb begin
      if (!st_valid_i)     action = ACT_IDLE;
      else if (may_merge)  action = ACT_MERGE;
      else if (!fifo_full) action = ACT_ALLOC;
      else                 action = ACT_BLOCK;
   end

   assign st_stall_o = fifo_full && !may_merge;
   assign alloc_w    = (action == ACT_ALLOC);
   assign merge_w    = (action == ACT_MERGE);
   assign dr_valid_o = !fifo_empty;
   assign drain_w    = dr_valid_o && dr_ready_i;
   assign empty_o    = fifo_empty;

   assign dr_line_o  = line_q[head_idx];
   assign dr_be_o    = be_q[head_idx];
   assign dr_data_o  = data_q[head_idx];

   // per entry storage
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic              v_r;
      logic              young_r;
      logic [LINE_AW-1:0] line_r;
      logic [LINE_BYTES-1:0] be_r;
      logic [DATA_W-1:0] data_r;
      logic              ent_alloc;
      logic              ent_merge;
      logic              ent_drain;

      assign ent_alloc = alloc_w && (free_idx == IDX_W'(e));
      assign ent_merge = merge_w && (merge_idx == IDX_W'(e));
      assign ent_drain = drain_w && (head_idx == IDX_W'(e));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            v_r     <= 1'b0;
            young_r <= 1'b0;
         end else if (ent_alloc) begin
            v_r     <= 1'b1;
            young_r <= 1'b1;
         end else if (ent_drain) begin
            v_r     <= 1'b0;
            young_r <= 1'b0;
         end else if (alloc_w && v_r && (line_r == st_line_i)) begin
            young_r <= 1'b0;
         end
      end

      always_ff @(posedge clk_i) begin
         if (ent_alloc) begin
            line_r <= st_line_i;
            be_r   <= st_be_i;
            for (int b = 0; b < LINE_BYTES; b++) begin
               data_r[b*8 +: 8] <= st_be_i[b] ? st_data_i[b*8 +: 8] : 8'h00;
            end
         end else if (ent_merge) begin
            be_r <= be_r | st_be_i;
            for (int b = 0; b < LINE_BYTES; b++) begin
               if (st_be_i[b]) data_r[b*8 +: 8] <= st_data_i[b*8 +: 8];
            end
         end
      end

      assign valid_q[e]  = v_r;
      assign latest_q[e] = young_r;
      assign line_q[e]   = line_r;
      assign be_q[e]     = be_r;
      assign data_q[e]   = data_r;
   end

   // stall only with every entry occupied (R6)
   assert_stall_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_stall_o |-> (&valid_q));

   // a new entry is only placed in a free slot (R2)
   assert_alloc_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alloc_w |-> any_free);

   // a merge targets an occupied entry that is not on the drain port (R4, R5)
   assert_merge_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      merge_w |-> (valid_q[merge_idx] && (merge_idx != head_idx)));

   // offered entry stays put until taken (R8)
   assert_drain_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dr_valid_o && !dr_ready_i) |=>
         (dr_valid_o && $stable(dr_line_o) && $stable(dr_be_o) && $stable(dr_data_o)));

   // empty flag agrees with entry occupancy (R9)
   assert_empty_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      empty_o == (valid_q == '0));

endmodule

// File: tb/wbuf_coalesce_tb_top.sv
`timescale 1ns/1ps
module wbuf_coalesce_tb_top;

   localparam int unsigned LAW = 28;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         coal_en = 1'b0;
   logic         st_valid = 1'b0;
   logic [LAW-1:0] st_line = '0;
   logic [15:0]  st_be = '0;
   logic [127:0] st_data = '0;
   logic         st_ok = 1'b0;
   logic         st_stall;
   logic         dr_valid;
   logic         dr_ready = 1'b0;
   logic [LAW-1:0] dr_line;
   logic [15:0]  dr_be;
   logic [127:0] dr_data;
   logic         empty;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wbuf_coalesce dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .coal_en_i    (coal_en),
      .st_valid_i   (st_valid),
      .st_line_i    (st_line),
      .st_be_i      (st_be),
      .st_data_i    (st_data),
      .st_coal_ok_i (st_ok),
      .st_stall_o   (st_stall),
      .dr_valid_o   (dr_valid),
      .dr_ready_i   (dr_ready),
      .dr_line_o    (dr_line),
      .dr_be_o      (dr_be),
      .dr_data_o    (dr_data),
      .empty_o      (empty)
   );

   // expected contents in drain order
   logic [LAW-1:0] m_line [16];
   logic [15:0]    m_be   [16];
   logic [127:0]   m_data [16];
   int             m_n = 0;

   typedef struct packed {
      logic         coal;
      logic         ok;
      logic [27:0]  line;
      logic [15:0]  be;
      logic [7:0]   tag;
      logic         merge;
   } vec_t;

   // stores walked with the drain port closed; merge column is the expected outcome
   localparam vec_t VECS [9] = '{
      '{1'b0, 1'b1, 28'h10, 16'h000F, 8'h10, 1'b0},
      '{1'b1, 1'b1, 28'h10, 16'h00F0, 8'h20, 1'b0}, // line of head entry: new entry (R5)
      '{1'b1, 1'b1, 28'h10, 16'h0F00, 8'h30, 1'b1}, // merge (R4)
      '{1'b1, 1'b0, 28'h20, 16'hFFFF, 8'h40, 1'b0}, // region permit off (R2)
      '{1'b1, 1'b1, 28'h10, 16'hF0F0, 8'h50, 1'b1}, // merge past a younger store (R10)
      '{1'b0, 1'b1, 28'h30, 16'h0001, 8'h60, 1'b0}, // global enable off (R2)
      '{1'b1, 1'b1, 28'h20, 16'h0003, 8'h70, 1'b1},
      '{1'b0, 1'b1, 28'h30, 16'h0002, 8'h80, 1'b0}, // second entry for line 0x30
      '{1'b1, 1'b1, 28'h30, 16'h0010, 8'h90, 1'b1}  // joins the younger copy (R11)
   };

   function automatic logic [127:0] mk_data(input logic [7:0] tag);
      logic [127:0] d;
      for (int k = 0; k < 16; k++) d[k*8 +: 8] = tag + 8'(k);
      return d;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model_add(input logic [LAW-1:0] line, input logic [15:0] be,
                            input logic [7:0] tag, input bit merge);
      logic [127:0] d = mk_data(tag);
      if (merge) begin
         for (int j = m_n - 1; j >= 0; j--) begin
            if (m_line[j] == line) begin
               m_be[j] = m_be[j] | be;
               for (int b = 0; b < 16; b++) if (be[b]) m_data[j][b*8 +: 8] = d[b*8 +: 8];
               break;
            end
         end
      end else begin
         m_line[m_n] = line;
         m_be[m_n]   = be;
         for (int b = 0; b < 16; b++) m_data[m_n][b*8 +: 8] = be[b] ? d[b*8 +: 8] : 8'h00;
         m_n++;
      end
   endtask

   task automatic do_store(input bit coal, input bit ok, input logic [LAW-1:0] line,
                           input logic [15:0] be, input logic [7:0] tag,
                           input bit merge, input bit exp_stall, input string req);
      @(negedge clk);
      coal_en  = coal;
      st_ok    = ok;
      st_line  = line;
      st_be    = be;
      st_data  = mk_data(tag);
      st_valid = 1'b1;
      #1;
      chk(st_stall == exp_stall, req, "st_stall_o", 128'(st_stall), 128'(exp_stall));
      @(posedge clk);
      #1;
      st_valid = 1'b0;
      if (!exp_stall) model_add(line, be, tag, merge);
   endtask

   task automatic drain_one(input string req);
      @(negedge clk);
      dr_ready = 1'b1;
      #1;
      chk(dr_valid == 1'b1, req, "dr_valid_o", 128'(dr_valid), 128'(1));
      chk(dr_line == m_line[0], req, "dr_line_o", 128'(dr_line), 128'(m_line[0]));
      chk(dr_be == m_be[0], req, "dr_be_o", 128'(dr_be), 128'(m_be[0]));
      chk(dr_data == m_data[0], req, "dr_data_o", dr_data, m_data[0]);
      @(posedge clk);
      #1;
      dr_ready = 1'b0;
      for (int j = 0; j < m_n - 1; j++) begin
         m_line[j] = m_line[j+1];
         m_be[j]   = m_be[j+1];
         m_data[j] = m_data[j+1];
      end
      m_n--;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [LAW-1:0] h_line;
      logic [15:0]    h_be;
      logic [127:0]   h_data;

      // reset state (R1, R9)
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(empty == 1'b1, "R1", "empty_o", 128'(empty), 128'(1));
      chk(dr_valid == 1'b0, "R1", "dr_valid_o", 128'(dr_valid), 128'(0));
      chk(st_stall == 1'b0, "R1", "st_stall_o", 128'(st_stall), 128'(0));

      // vector table walk with drain closed
      foreach (VECS[i]) begin
         do_store(VECS[i].coal, VECS[i].ok, VECS[i].line, VECS[i].be, VECS[i].tag,
                  VECS[i].merge, 1'b0, "R4");
      end
      @(negedge clk);
      chk(empty == 1'b0, "R9", "empty_o busy", 128'(empty), 128'(0));
      // drain order and contents (R2, R3, R10, R11)
      while (m_n > 0) drain_one("R10");
      @(negedge clk);
      chk(empty == 1'b1, "R9", "empty_o drained", 128'(empty), 128'(1));
      chk(dr_valid == 1'b0, "R2", "dr_valid_o drained", 128'(dr_valid), 128'(0));

      // fill every entry
      for (int i = 0; i < 8; i++) begin
         do_store(1'b0, 1'b1, LAW'(28'h100 + i), 16'h0001 << i, 8'(8'hA0 + i), 1'b0, 1'b0, "R2");
      end
      // full, no merge possible: stall (R6)
      do_store(1'b0, 1'b1, 28'h200, 16'hFFFF, 8'hE0, 1'b0, 1'b1, "R6");
      // full, merge into a non-head entry: accepted (R7)
      do_store(1'b1, 1'b1, 28'h103, 16'h0F00, 8'hC0, 1'b1, 1'b0, "R7");
      // full, only match is the head entry: stall (R5)
      do_store(1'b1, 1'b1, 28'h100, 16'hFF00, 8'hD0, 1'b0, 1'b1, "R5");

      // drain port held while not ready (R8)
      @(negedge clk);
      h_line = dr_line;
      h_be   = dr_be;
      h_data = dr_data;
      repeat (3) begin
         @(negedge clk);
         chk(dr_valid && dr_line == h_line && dr_be == h_be && dr_data == h_data,
             "R8", "drain hold", dr_data, h_data);
      end

      drain_one("R8");
      // one slot free again: non-merging store taken (R6)
      do_store(1'b0, 1'b1, 28'h200, 16'h8001, 8'hF0, 1'b0, 1'b0, "R6");
      while (m_n > 0) drain_one("R2");
      @(negedge clk);
      chk(empty == 1'b1, "R9", "empty_o final", 128'(empty), 128'(1));
      chk(dr_valid == 1'b0, "R6", "stalled store not buffered", 128'(dr_valid), 128'(0));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule